// File: doc/BRIEF.md
# Sliding-Window Cluster Finder Tile

This block finds energy clusters in one tile of a calorimeter trigger-tower grid. For each bunch crossing it receives a square map of 8-bit transverse-energy values. The map holds a core of `CORE_N` x `CORE_N` towers with a ring of `BORDER_N` towers on every side. Each core position anchors a 2x2 candidate window whose sum is the cluster energy. A candidate becomes a cluster when two conditions hold. First, its sum must be a local maximum against the eight windows shifted by one tower. Second, it must reach a programmable threshold. Each cluster is reported together with the 4x4 energy centred on that window, for jet-type decisions and track matching.

A one-cycle `start` pulse loads the map and the threshold. The tile then walks the core positions in raster order, one position per clock. Every qualifying position produces one beat on a valid/data stream carrying its row, column, 2x2 energy and 4x4 energy. The border towers let a tile decide clusters on its own core edge without talking to neighbouring tiles.

Top module: `sw_cluster_tile`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `cl_valid` are 0.
- R2: When `start` is sampled high while idle, `busy` is high for exactly `CORE_N*CORE_N` cycles. The result for raster position k (k = row*CORE_N + col, counting from 0) appears on the output registers k+1 cycles after the accepting edge. No beat appears outside a scan.
- R3: A `start` pulse, a new `tower_map` or a new `thresh` applied while `busy` is high has no effect on the running scan, and no second scan follows.
- R4: Tower (r,c) of the map sits at bits `[(r*GRID+c)*8 +: 8]`, with GRID = CORE_N + 2*BORDER_N and rows and columns counted from 0 including the border. Core position (row,col) anchors the 2x2 window on towers (row+B..row+B+1, col+B..col+B+1), where B = BORDER_N. `cl_et` is that window's sum. `cl_jet` is the 4x4 sum over towers (row+B-1..row+B+2, col+B-1..col+B+2).
- R5: A candidate is a local maximum when both of the following hold. Its sum must be strictly greater than each neighbour window that comes earlier in raster order (row offset -1, or row offset 0 with column offset -1). It must also be greater than or equal to the other four neighbours. Thus on a flat plateau only the earliest-placed window can win, and a uniform map yields no cluster.
- R6: A local maximum is reported only if its 2x2 sum is greater than or equal to the threshold captured at `start`.
- R7: Reported clusters come out in increasing raster order, exactly one beat per qualifying position, with `cl_row` and `cl_col` in core coordinates.
- R8: Edge candidates use border towers. A lone hot tower on the first core tower yields no cluster in this tile, because an earlier window containing it equals it. A lone hot tower on the last core tower yields one cluster, one row and one column up-left of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load map and threshold and begin a scan (ignored while busy) |
| thresh | input | ET_W+2 | Minimum 2x2 energy for a reported cluster |
| tower_map | input | GRID*GRID*ET_W | Tower energies, core plus border, row-major |
| busy | output | 1 | Scan in progress |
| cl_valid | output | 1 | Cluster beat valid |
| cl_row | output | log2(CORE_N) | Core row of the cluster |
| cl_col | output | log2(CORE_N) | Core column of the cluster |
| cl_et | output | ET_W+2 | 2x2 window energy |
| cl_jet | output | ET_W+4 | 4x4 energy around the window |

## Verification
Two functions can fall in the same cycle: emitting a cluster beat from the running scan, and receiving a new start request together with a new map and threshold. The bench provokes this by driving a fresh `start`, an inverted map and a zero threshold in the middle of a scan over a dense random map. It judges the outcome by requiring the stream to match the model of the original map beat for beat, and by requiring that no second scan starts once `busy` falls. Flat plateaus, small-value maps rich in ties, and lone hot towers on the core edges test the tie rule against an independent model.

// File: rtl/sw_pkg.sv
package sw_pkg;

    // Scan controller state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    // How a candidate compares against one neighbour window
    typedef enum logic {
        CMP_LOOSE  = 1'b0,   // candidate >= neighbour
        CMP_STRICT = 1'b1    // candidate >  neighbour
    } cmp_rule_e;

    // Neighbours earlier in raster order must be beaten strictly
    function automatic cmp_rule_e rule_for(input int dr, input int dc);
        return ((dr < 0) || (dr == 0 && dc < 0)) ? CMP_STRICT : CMP_LOOSE;
    endfunction

endpackage

// File: rtl/sw_scan_ctrl.sv
module sw_scan_ctrl
    import sw_pkg::*;
#(
    parameter int NPOS  = 64,
    parameter int IDX_W = $clog2(NPOS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             load,
    output logic [IDX_W-1:0] idx
);

    scan_st_e         st_q;
    logic [IDX_W-1:0] idx_q;

    assign load = start && (st_q == ST_IDLE);
    assign busy = (st_q == ST_SCAN);
    assign idx  = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_SCAN;
                        idx_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (idx_q == IDX_W'(NPOS - 1)) begin
                        st_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sw_window_sum.sv
module sw_window_sum #(
    parameter int ET_W   = 8,
    parameter int SUM2_W = ET_W + 2,
    parameter int JET_W  = ET_W + 4
) (
    input  logic [ET_W-1:0]   patch [4][4],
    output logic [SUM2_W-1:0] win   [3][3],
    output logic [JET_W-1:0]  jet
);

    // Nine overlapping 2x2 sums; win[1][1] is the candidate
    for (genvar a = 0; a < 3; a++) begin : g_wr
        for (genvar b = 0; b < 3; b++) begin : g_wc
            assign win[a][b] = SUM2_W'(patch[a][b])   + SUM2_W'(patch[a][b+1])
                             + SUM2_W'(patch[a+1][b]) + SUM2_W'(patch[a+1][b+1]);
        end
    end

    // 4x4 energy around the candidate
    always_comb begin
        jet = '0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                jet = jet + JET_W'(patch[i][j]);
            end
        end
    end

endmodule

// File: rtl/sw_peak_judge.sv
module sw_peak_judge
    import sw_pkg::*;
#(
    parameter int SUM2_W = 10
) (
    input  logic [SUM2_W-1:0] win [3][3],
    input  logic [SUM2_W-1:0] thr,
    output logic              hit
);

    logic [8:0] beat;

    for (genvar a = 0; a < 3; a++) begin : g_nr
        for (genvar b = 0; b < 3; b++) begin : g_nc
            localparam cmp_rule_e RULE = rule_for(a - 1, b - 1);
            if (a == 1 && b == 1) begin : g_self
                assign beat[a*3+b] = 1'b1;
            end else if (RULE == CMP_STRICT) begin : g_gt
                assign beat[a*3+b] = win[1][1] > win[a][b];
            end else begin : g_ge
                assign beat[a*3+b] = win[1][1] >= win[a][b];
            end
        end
    end

    assign hit = (&beat) && (win[1][1] >= thr);

endmodule

// File: rtl/sw_cluster_tile.sv
module sw_cluster_tile
    import sw_pkg::*;
#(
    parameter int CORE_N   = 8,
    parameter int BORDER_N = 2,
    parameter int ET_W     = 8,
    parameter int GRID     = CORE_N + 2 * BORDER_N,
    parameter int POS_W    = $clog2(CORE_N),
    parameter int SUM2_W   = ET_W + 2,
    parameter int JET_W    = ET_W + 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [SUM2_W-1:0]           thresh,
    input  logic [GRID*GRID*ET_W-1:0]   tower_map,
    output logic                        busy,
    output logic                        cl_valid,
    output logic [POS_W-1:0]            cl_row,
    output logic [POS_W-1:0]            cl_col,
    output logic [SUM2_W-1:0]           cl_et,
    output logic [JET_W-1:0]            cl_jet
);

    localparam int NPOS  = CORE_N * CORE_N;
    localparam int IDX_W = 2 * POS_W;
    localparam int MAP_W = GRID * GRID * ET_W;

    logic             load;
    logic [IDX_W-1:0] idx;
    logic [POS_W-1:0] row, col;
    logic [MAP_W-1:0] map_q;
    logic [SUM2_W-1:0] thr_q;

    sw_scan_ctrl #(.NPOS(NPOS), .IDX_W(IDX_W)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (busy),
        .load (load),
        .idx  (idx)
    );

    // Snapshot of the crossing
    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
            thr_q <= '0;
        end else if (load) begin
            map_q <= tower_map;
            thr_q <= thresh;
        end
    end

    assign row = idx[IDX_W-1:POS_W];
    assign col = idx[POS_W-1:0];

    // 4x4 patch starting one tower up-left of the candidate window
    logic [ET_W-1:0] patch [4][4];
    for (genvar i = 0; i < 4; i++) begin : g_pr
        for (genvar j = 0; j < 4; j++) begin : g_pc
            assign patch[i][j] = map_q[((int'(row) + BORDER_N - 1 + i) * GRID
                                       + int'(col) + BORDER_N - 1 + j) * ET_W +: ET_W];
        end
    end

    logic [SUM2_W-1:0] win [3][3];
    logic [JET_W-1:0]  jet;
    logic              hit;

    sw_window_sum #(.ET_W(ET_W), .SUM2_W(SUM2_W), .JET_W(JET_W)) u_sum (
        .patch(patch),
        .win  (win),
        .jet  (jet)
    );

    sw_peak_judge #(.SUM2_W(SUM2_W)) u_judge (
        .win(win),
        .thr(thr_q),
        .hit(hit)
    );

    // Output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            cl_valid <= 1'b0;
            cl_row   <= '0;
            cl_col   <= '0;
            cl_et    <= '0;
            cl_jet   <= '0;
        end else begin
            cl_valid <= busy && hit;
            if (busy) begin
                cl_row <= row;
                cl_col <= col;
                cl_et  <= win[1][1];
                cl_jet <= jet;
            end
        end
    end

endmodule

// File: rtl/sw_cluster_tile_chk.sv
module sw_cluster_tile_chk #(
    parameter int NPOS   = 64,
    parameter int IDX_W  = 6,
    parameter int SUM2_W = 10,
    parameter int JET_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              cl_valid,
    input logic [SUM2_W-1:0] cl_et,
    input logic [JET_W-1:0]  cl_jet,
    input logic [SUM2_W-1:0] thr_q,
    input logic [IDX_W-1:0]  scan_idx
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !cl_valid));

    p_valid_in_scan_r2: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> $past(busy));

    p_scan_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(scan_idx) == IDX_W'(NPOS - 1)));

    p_hold_thr_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(thr_q));

    p_jet_cover_r4: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> (cl_jet >= JET_W'(cl_et)));

    p_thresh_met_r6: assert property (@(posedge clk) disable iff (rst)
        cl_valid |-> (cl_et >= thr_q));

    p_raster_step_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (scan_idx == $past(scan_idx) + 1'b1));

endmodule

bind sw_cluster_tile sw_cluster_tile_chk #(
    .NPOS  (NPOS),
    .IDX_W (IDX_W),
    .SUM2_W(SUM2_W),
    .JET_W (JET_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cl_valid(cl_valid),
    .cl_et   (cl_et),
    .cl_jet  (cl_jet),
    .thr_q   (thr_q),
    .scan_idx(idx)
);

// File: tb/sim_sw_cluster_tile.sv
module sim_sw_cluster_tile;

    localparam int CORE = 8;
    localparam int BRD  = 2;
    localparam int GRID = CORE + 2 * BRD;
    localparam int NPOS = CORE * CORE;
    localparam int MAPW = GRID * GRID * 8;

    typedef struct packed {
        logic [3:0]  kind;     // 0 random, 1 uniform, 2 small ties, 3 sparse, 4 ramp
        logic [31:0] seed;
        logic [9:0]  thr;
        logic [7:0]  exp_cnt;  // 8'hFF: no hand-computed count
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{4'd0, 32'd1,   10'd0,   8'hFF},
        '{4'd0, 32'd77,  10'd600, 8'hFF},
        '{4'd1, 32'd9,   10'd0,   8'd0},
        '{4'd2, 32'd5,   10'd0,   8'hFF},
        '{4'd2, 32'd31,  10'd4,   8'hFF},
        '{4'd3, 32'd3,   10'd20,  8'hFF},
        '{4'd4, 32'd0,   10'd0,   8'hFF}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [9:0]      thresh = '0;
    logic [MAPW-1:0] tower_map = '0;
    logic            busy, cl_valid;
    logic [2:0]      cl_row, cl_col;
    logic [9:0]      cl_et;
    logic [11:0]     cl_jet;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lcg;

    always #2 clk = ~clk;

    sw_cluster_tile u0 (
        .clk(clk), .rst(rst), .start(start), .thresh(thresh), .tower_map(tower_map),
        .busy(busy), .cl_valid(cl_valid), .cl_row(cl_row), .cl_col(cl_col),
        .cl_et(cl_et), .cl_jet(cl_jet)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int rnd8();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'(lcg[23:16]);
    endfunction

    function automatic int tw(input logic [MAPW-1:0] m, input int r, input int c);
        return int'(m[(r*GRID+c)*8 +: 8]);
    endfunction

    function automatic int ws(input logic [MAPW-1:0] m, input int r, input int c);
        return tw(m,r,c) + tw(m,r,c+1) + tw(m,r+1,c) + tw(m,r+1,c+1);
    endfunction

    // Reference model for one core position
    task automatic model(input logic [MAPW-1:0] m, input int thr, input int row, input int col,
                         output bit hit, output int et, output int jet);
        int rr, cc, n;
        bit ok;
        rr = row + BRD; cc = col + BRD;
        et = ws(m, rr, cc);
        ok = 1'b1;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                if (dr != 0 || dc != 0) begin
                    n = ws(m, rr+dr, cc+dc);
                    if (dr < 0 || (dr == 0 && dc < 0)) begin
                        if (!(et > n)) ok = 1'b0;
                    end else begin
                        if (!(et >= n)) ok = 1'b0;
                    end
                end
            end
        end
        hit = ok && (et >= thr);
        jet = 0;
        for (int i = -1; i <= 2; i++)
            for (int j = -1; j <= 2; j++)
                jet += tw(m, rr+i, cc+j);
    endtask

    task automatic gen_map(input int kind, input logic [31:0] seed, output logic [MAPW-1:0] m);
        int r, c, v;
        lcg = seed;
        m = '0;
        for (int t = 0; t < GRID*GRID; t++) begin
            r = t / GRID; c = t % GRID;
            case (kind)
                0: v = rnd8();
                1: v = int'(seed[7:0]);
                2: v = rnd8() % 4;
                4: v = r * 8 + c * 2;
                default: v = 0;
            endcase
            m[t*8 +: 8] = 8'(v);
        end
        if (kind == 3) begin
            for (int p = 0; p < 6; p++) begin
                r = rnd8() % GRID; c = rnd8() % GRID; v = 1 + rnd8() % 255;
                m[(r*GRID+c)*8 +: 8] = 8'(v);
            end
        end
    endtask

    // Run one scan and compare every beat with the model
    task automatic run_scan(input logic [MAPW-1:0] m, input int thr, input bit disturb,
                            input string tag, output int cnt);
        bit hit; int et, jet;
        cnt = 0;
        @(negedge clk);
        tower_map = m; thresh = 10'(thr); start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= NPOS; k++) begin
            @(posedge clk); @(negedge clk);
            model(m, thr, (k-1) / CORE, (k-1) % CORE, hit, et, jet);
            check({tag, " R2 busy"}, int'(busy), (k < NPOS) ? 1 : 0);
            check({tag, " R5/R6 valid"}, int'(cl_valid), int'(hit));
            if (cl_valid && hit) begin
                cnt++;
                check({tag, " R7 row/col"}, int'(cl_row)*CORE + int'(cl_col), k-1);
                check({tag, " R4 et"}, int'(cl_et), et);
                check({tag, " R4 jet"}, int'(cl_jet), jet);
            end
            if (disturb && k == 10) begin
                start = 1'b1; tower_map = ~m; thresh = '0;
            end
            if (disturb && k == 11) start = 1'b0;
        end
        @(posedge clk); @(negedge clk);
        check({tag, " R3 no restart busy"}, int'(busy), 0);
        check({tag, " R3 no restart valid"}, int'(cl_valid), 0);
    endtask

    function automatic logic [MAPW-1:0] hot(input int r, input int c, input int v);
        logic [MAPW-1:0] m = '0;
        m[(r*GRID+c)*8 +: 8] = 8'(v);
        return m;
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin : main
        logic [MAPW-1:0] m;
        int cnt;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 valid in reset", int'(cl_valid), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 valid after reset", int'(cl_valid), 0);

        // Table walk: R2 R4 R5 R6 R7
        foreach (VEC[i]) begin
            gen_map(int'(VEC[i].kind), VEC[i].seed, m);
            run_scan(m, int'(VEC[i].thr), 1'b0, $sformatf("vec%0d", i), cnt);
            if (VEC[i].exp_cnt != 8'hFF)
                check($sformatf("vec%0d R5 plateau count", i), cnt, int'(VEC[i].exp_cnt));
        end

        // R8: edge cases with lone hot towers
        run_scan(hot(BRD, BRD, 50), 1, 1'b0, "first core tower", cnt);
        check("R8 first core tower count", cnt, 0);
        run_scan(hot(BRD+CORE-1, BRD+CORE-1, 50), 1, 1'b0, "last core tower", cnt);
        check("R8 last core tower count", cnt, 1);
        run_scan(hot(1, 1, 90), 1, 1'b0, "border tower", cnt);
        check("R8 border tower count", cnt, 0);

        // R6: threshold equal passes, one above fails
        run_scan(hot(5, 5, 100), 100, 1'b0, "thr equal", cnt);
        check("R6 threshold equal count", cnt, 1);
        run_scan(hot(5, 5, 100), 101, 1'b0, "thr above", cnt);
        check("R6 threshold above count", cnt, 0);

        // R3: start, map and threshold changes during a scan
        gen_map(0, 32'd4242, m);
        run_scan(m, 0, 1'b1, "disturb", cnt);

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule